// File: doc/BRIEF.md
# Nine-Operand Carry-Save Adder Tree

This block adds nine unsigned operands of a parameterised width and returns their exact total. The operands reach it as one flat bus, with operand k in bits [k*WIDTH +: WIDTH]. Columns of full-adder cells and four-input compressor cells cut the nine values down to two. The cells never pass a carry along a whole row. Only one carry-propagate adder sits at the end, and it turns the last two vectors into the result.

The reduction can be built in two ways, chosen by the TOPOLOGY parameter. With TOPOLOGY=0, three-input rows come first: nine values become six, then four, and a single four-input row brings them to two. With TOPOLOGY=1, four-input rows come first: two of them handle eight operands, a third takes four of the five values that remain, and one three-input row produces the final pair. Every intermediate vector is as wide as the output. Each carry vector sits one place left of its sum vector, so bits of equal weight always meet in the same column.

The result is WIDTH+4 bits wide, which holds 9*(2^WIDTH-1) with no loss. When REGISTER_OUTPUT=1 the total is captured on the rising clock edge, and an active-high synchronous reset clears it. When REGISTER_OUTPUT=0 the output is purely combinational. The block has no flow control: it accepts a new operand set every cycle and never stalls, so it exerts no back-pressure.

Top module: `csa9_tree`

## Requirements
- R1: sum_o equals the arithmetic sum of the nine unsigned operands, where operand k is operands_i[k*WIDTH +: WIDTH], for any operand values.
- R2: With every operand bit set, sum_o is exactly 9*(2^WIDTH-1). No carry ever leaves the top of the WIDTH+4-bit width, in any compressor row or in the final adder.
- R3: TOPOLOGY=0 (three-input rows first) and TOPOLOGY=1 (four-input rows first) give identical sums for every operand set.
- R4: If exactly one bit, at position b, is set in any one operand and all other bits are zero, sum_o is exactly 2^b.
- R5: If the same bit position b is set in any subset of the operands and all other bits are zero, sum_o equals (number of operands in the subset)*2^b. This covers every column count from 0 to 9.
- R6: With REGISTER_OUTPUT=1, sum_o shows the total of the operands present at a rising edge. It keeps that value until the next rising edge, even if the operands change in between.
- R7: With REGISTER_OUTPUT=1, rst_i high at a rising edge makes sum_o zero after that edge, whatever the operands are.
- R8: With REGISTER_OUTPUT=0, sum_o follows the operands without waiting for a clock edge, and rst_i has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register and the checks |
| rst_i | input | 1 | Synchronous active-high reset of the output register |
| operands_i | input | 9*WIDTH | Nine unsigned operands; operand k in bits [k*WIDTH +: WIDTH] |
| sum_o | output | WIDTH+4 | Full-precision total of the nine operands |

## Verification
The bench sweeps bit columns. For every bit position, it tries every subset of operands that has that bit set. This drives each column count from zero to nine. A cell that mishandled one count, or a four-input cell whose lateral carry was lost or sent to the wrong column, would give a total that is wrong by a multiple of that column's weight. Single-bit walks through every operand slot catch an operand wired at the wrong weight or dropped. The all-ones set catches a top carry that is truncated. Comparing the two topologies on the same input, together with changing the operands between edges and asserting reset while the operands are nonzero, exposes a topology-specific wiring slip, an output register that does not hold its value, and a reset that fails to clear.

// File: rtl/csa9_pkg.sv
`timescale 1ns/1ps
package csa9_pkg;
  // number of operands summed by the tree
  localparam int unsigned NUM_OPS = 9;
  // bits of growth needed so that NUM_OPS*(2^W-1) always fits
  localparam int unsigned GROWTH  = $clog2(NUM_OPS + 1);
endpackage

// File: rtl/csa9_fa.sv
`timescale 1ns/1ps
// One column of a 3:2 compressor: weight-1 sum, weight-2 carry.
module csa9_fa (
  input  logic x_i,
  input  logic y_i,
  input  logic z_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = x_i ^ y_i ^ z_i;
  assign c_o = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
endmodule

// File: rtl/csa9_row32.sv
`timescale 1ns/1ps
// A row of 3:2 compressors across W columns. The carry vector is already
// shifted one column up, so it aligns with the sum vector.
module csa9_row32 #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o,
  output logic         spill_o
);
  logic [W-1:0] maj;

  for (genvar k = 0; k < W; k++) begin : g_col
    csa9_fa u_fa (
      .x_i(a_i[k]),
      .y_i(b_i[k]),
      .z_i(c_i[k]),
      .s_o(sum_o[k]),
      .c_o(maj[k])
    );
  end

  assign carry_o = maj << 1;
  // carry out of the top column; weight 2^W
  assign spill_o = maj[W-1];
endmodule

// File: rtl/csa9_row42.sv
`timescale 1ns/1ps
// A row of 4:2 compressors. Each column holds two cascaded 3:2 cells.
// The lateral carry out of a column comes from a, b and c only, so it
// never ripples through the row.
module csa9_row42 #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o,
  output logic [1:0]   spill_o
);
  logic [W-1:0] mid;
  logic [W-1:0] lat;
  logic [W-1:0] lat_in;
  logic [W-1:0] maj;

  // lateral carries step one column up; the lowest column gets zero
  assign lat_in = lat << 1;

  for (genvar k = 0; k < W; k++) begin : g_col
    csa9_fa u_upper (
      .x_i(a_i[k]),
      .y_i(b_i[k]),
      .z_i(c_i[k]),
      .s_o(mid[k]),
      .c_o(lat[k])
    );
    csa9_fa u_lower (
      .x_i(mid[k]),
      .y_i(d_i[k]),
      .z_i(lat_in[k]),
      .s_o(sum_o[k]),
      .c_o(maj[k])
    );
  end

  assign carry_o = maj << 1;
  // both weight-2^W bits that leave the top column
  assign spill_o = {lat[W-1], maj[W-1]};
endmodule

// File: rtl/csa9_cpa.sv
`timescale 1ns/1ps
// Final carry-propagate adder of the two reduced vectors.
module csa9_cpa #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  assign {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i};
endmodule

// File: rtl/csa9_tree.sv
`timescale 1ns/1ps
module csa9_tree
  import csa9_pkg::*;
#(
  parameter int WIDTH           = 8,
  parameter int TOPOLOGY        = 0,
  parameter bit REGISTER_OUTPUT = 1'b1
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic [NUM_OPS*WIDTH-1:0]   operands_i,
  output logic [WIDTH+GROWTH-1:0]    sum_o
);
  localparam int OUT_W = WIDTH + GROWTH;
  localparam int EW    = OUT_W + 3;
  localparam int NR32  = (TOPOLOGY == 0) ? 5 : 1;
  localparam int NR42  = (TOPOLOGY == 0) ? 1 : 3;

  logic [OUT_W-1:0] xo [NUM_OPS];

  logic [OUT_W-1:0] t_a [NR32];
  logic [OUT_W-1:0] t_b [NR32];
  logic [OUT_W-1:0] t_c [NR32];
  logic [OUT_W-1:0] t_s [NR32];
  logic [OUT_W-1:0] t_y [NR32];
  logic             t_sp [NR32];

  logic [OUT_W-1:0] q_a [NR42];
  logic [OUT_W-1:0] q_b [NR42];
  logic [OUT_W-1:0] q_c [NR42];
  logic [OUT_W-1:0] q_d [NR42];
  logic [OUT_W-1:0] q_s [NR42];
  logic [OUT_W-1:0] q_y [NR42];
  logic [1:0]       q_sp [NR42];

  logic [OUT_W-1:0] fin_a;
  logic [OUT_W-1:0] fin_b;
  logic [OUT_W-1:0] total;
  logic             fin_cout;

  // widen every operand to the output width
  for (genvar k = 0; k < NUM_OPS; k++) begin : g_ext
    assign xo[k] = OUT_W'(operands_i[k*WIDTH +: WIDTH]);
  end

  // three-input rows
  for (genvar i = 0; i < NR32; i++) begin : g_r32
    csa9_row32 #(.W(OUT_W)) u_row (
      .a_i(t_a[i]), .b_i(t_b[i]), .c_i(t_c[i]),
      .sum_o(t_s[i]), .carry_o(t_y[i]), .spill_o(t_sp[i])
    );
    // the row keeps the weighted total of its inputs (R1)
    p_row_conserve_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      (EW'(t_a[i]) + EW'(t_b[i]) + EW'(t_c[i])) ==
      (EW'(t_s[i]) + EW'(t_y[i]) + (EW'(t_sp[i]) << OUT_W)));
    p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      t_sp[i] == 1'b0);
  end

  // four-input rows
  for (genvar i = 0; i < NR42; i++) begin : g_r42
    csa9_row42 #(.W(OUT_W)) u_row (
      .a_i(q_a[i]), .b_i(q_b[i]), .c_i(q_c[i]), .d_i(q_d[i]),
      .sum_o(q_s[i]), .carry_o(q_y[i]), .spill_o(q_sp[i])
    );
    // lateral carries must land in the next column, none lost (R1)
    p_quad_conserve_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      (EW'(q_a[i]) + EW'(q_b[i]) + EW'(q_c[i]) + EW'(q_d[i])) ==
      (EW'(q_s[i]) + EW'(q_y[i]) + (EW'(q_sp[i][0]) << OUT_W) +
       (EW'(q_sp[i][1]) << OUT_W)));
    p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      q_sp[i] == 2'b00);
  end

  // reduction wiring; every pairing keeps equal weights aligned
  if (TOPOLOGY == 0) begin : g_topo_a
    // 9 -> 6
    assign t_a[0] = xo[0];  assign t_b[0] = xo[1];  assign t_c[0] = xo[2];
    assign t_a[1] = xo[3];  assign t_b[1] = xo[4];  assign t_c[1] = xo[5];
    assign t_a[2] = xo[6];  assign t_b[2] = xo[7];  assign t_c[2] = xo[8];
    // 6 -> 4
    assign t_a[3] = t_s[0]; assign t_b[3] = t_y[0]; assign t_c[3] = t_s[1];
    assign t_a[4] = t_y[1]; assign t_b[4] = t_s[2]; assign t_c[4] = t_y[2];
    // 4 -> 2
    assign q_a[0] = t_s[3]; assign q_b[0] = t_y[3];
    assign q_c[0] = t_s[4]; assign q_d[0] = t_y[4];
    assign fin_a  = q_s[0];
    assign fin_b  = q_y[0];
  end else begin : g_topo_b
    // 8 -> 4, ninth operand waits
    assign q_a[0] = xo[0];  assign q_b[0] = xo[1];
    assign q_c[0] = xo[2];  assign q_d[0] = xo[3];
    assign q_a[1] = xo[4];  assign q_b[1] = xo[5];
    assign q_c[1] = xo[6];  assign q_d[1] = xo[7];
    // 4 of 5 -> 2, leaving three
    assign q_a[2] = q_s[0]; assign q_b[2] = q_y[0];
    assign q_c[2] = q_s[1]; assign q_d[2] = q_y[1];
    // 3 -> 2
    assign t_a[0] = q_s[2]; assign t_b[0] = q_y[2]; assign t_c[0] = xo[8];
    assign fin_a  = t_s[0];
    assign fin_b  = t_y[0];
  end

  csa9_cpa #(.W(OUT_W)) u_cpa (
    .a_i(fin_a), .b_i(fin_b), .sum_o(total), .cout_o(fin_cout)
  );

  p_cpa_no_overflow_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    fin_cout == 1'b0);

  if (REGISTER_OUTPUT) begin : g_reg
    logic [OUT_W-1:0] sum_q;
    always_ff @(posedge clk_i) begin
      if (rst_i) sum_q <= '0;
      else       sum_q <= total;
    end
    assign sum_o = sum_q;

    p_reg_latency_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> sum_o == $past(total));
    p_reset_zero_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rst_i) |-> sum_o == '0);
  end else begin : g_comb
    assign sum_o = total;
  end
endmodule

// File: tb/csa9_tree_tb.sv
`timescale 1ns/1ps
module csa9_tree_tb;
  import csa9_pkg::*;

  localparam int W  = 4;
  localparam int OW = W + GROWTH;
  localparam int IW = NUM_OPS * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [IW-1:0] ops = '0;
  logic [OW-1:0] sum_a;
  logic [OW-1:0] sum_b;
  logic [OW-1:0] sum_c;
  logic [OW-1:0] prev_exp = '0;
  int            checks = 0;
  int            errors = 0;

  always #2.5 clk = ~clk;

  // registered, three-input rows first
  csa9_tree #(.WIDTH(W), .TOPOLOGY(0), .REGISTER_OUTPUT(1'b1)) u_dut (
    .clk_i(clk), .rst_i(rst), .operands_i(ops), .sum_o(sum_a));
  // registered, four-input rows first
  csa9_tree #(.WIDTH(W), .TOPOLOGY(1), .REGISTER_OUTPUT(1'b1)) u_dut_b (
    .clk_i(clk), .rst_i(rst), .operands_i(ops), .sum_o(sum_b));
  // combinational
  csa9_tree #(.WIDTH(W), .TOPOLOGY(0), .REGISTER_OUTPUT(1'b0)) u_dut_c (
    .clk_i(clk), .rst_i(rst), .operands_i(ops), .sum_o(sum_c));

  function automatic logic [OW-1:0] ref_sum(input logic [IW-1:0] v);
    logic [OW-1:0] acc = '0;
    for (int k = 0; k < NUM_OPS; k++) acc += OW'(v[k*W +: W]);
    return acc;
  endfunction

  task automatic check(input string tag, input logic [OW-1:0] act,
                       input logic [OW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive at the falling edge, check the combinational output and the held
  // register value, then check both registered outputs after the rising edge
  task automatic apply(input logic [IW-1:0] v, input string tag);
    @(negedge clk);
    ops = v;
    #1;
    check({tag, " R8 comb"}, sum_c, ref_sum(v));
    check({tag, " R6 hold A"}, sum_a, prev_exp);
    check({tag, " R6 hold B"}, sum_b, prev_exp);
    @(posedge clk);
    #1;
    check({tag, " A"}, sum_a, ref_sum(v));
    check({tag, " B"}, sum_b, ref_sum(v));
    check("R3 topologies agree", sum_a, sum_b);
    prev_exp = ref_sum(v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [IW-1:0] v;
    // reset with nonzero operands
    ops = '1;
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset A", sum_a, '0);
    check("R7 reset B", sum_b, '0);
    check("R8 comb ignores reset", sum_c, ref_sum('1));
    @(negedge clk);
    rst = 1'b0;
    ops = '0;
    prev_exp = '0;

    apply('0, "R1 zeros");
    apply('1, "R2 all ones");
    check("R2 all ones value", sum_a, OW'(9 * ((1 << W) - 1)));

    // R4 walking single bit through every operand slot and bit
    for (int k = 0; k < NUM_OPS; k++) begin
      for (int b = 0; b < W; b++) begin
        v = '0;
        v[k*W + b] = 1'b1;
        apply(v, "R4 walk");
        check("R4 walk weight", sum_a, OW'(1) << b);
      end
    end

    // R5 every subset of operands on one column
    for (int b = 0; b < W; b++) begin
      for (int m = 0; m < (1 << NUM_OPS); m++) begin
        v = '0;
        for (int k = 0; k < NUM_OPS; k++) v[k*W + b] = m[k];
        apply(v, "R5 column");
        check("R5 column count", sum_a, OW'($countones(m[NUM_OPS-1:0])) << b);
      end
    end

    // R1 random operand sets
    for (int n = 0; n < 10000; n++) begin
      apply(IW'({$urandom(), $urandom()}), "R1 random");
    end

    // R7 reset in mid-run with all-ones operands
    @(negedge clk);
    ops = '1;
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R7 mid reset A", sum_a, '0);
    check("R7 mid reset B", sum_b, '0);
    check("R8 comb during reset", sum_c, ref_sum('1));
    @(negedge clk);
    rst = 1'b0;
    ops = '0;
    prev_exp = '0;
    apply('1, "R1 after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule